// File: doc/BRIEF.md
# Three-Wire Synthesizer Register Interface

This block is the configuration port of a multi-loop frequency synthesizer. A host drives three wires: a serial clock, a serial data line and an active-low enable. While the enable is low, each rising edge of the serial clock shifts one data bit into a 22-bit shift register. When the enable returns high, the block splits the word into a 4-bit address and an 18-bit data field and writes the data into one of nine control registers. The port accepts writes in every powerdown state, because it reads no power control.

All three wires are asynchronous to the system clock. Each one passes through a two-flop synchronizer, and the block finds serial clock and enable edges in the system clock domain. The stored settings leave the block as decoded fields: output selection, reference and output division, power control, phase detector gains, and the N and R divider values for the two RF loops and the IF loop. Writing any divider of an RF loop makes that loop the active RF loop. Committing any N or R divider raises a one-cycle change strobe for its loop, so a tuning sequencer can start a new tuning run.

Top module: `synth_cfg_port`

## Requirements
- R1: A word is the last 22 bits shifted. The first 4 of those bits are the address, most significant bit first. The remaining 18 bits are data, ending with data bit 0. The word is written into the addressed register on the rising edge of the enable. The decoded outputs change three system clocks after the enable rises at the synchronizer input.
- R2: Any number of extra bits shifted before the final 22 has no effect on the stored result.
- R3: Serial clock edges that occur while the enable is high do not shift the register. A later frame with no clock edges commits the previously shifted word unchanged.
- R4: Address 0 holds the main settings. Data bits 13:12 give aux_sel, bits 11:10 give if_div, bit 6 gives ref_div2, bit 5 gives low_pwr and bit 3 gives auto_pd. All other data bits of this register are dropped.
- R5: Address 1 holds the gains: kp_rf1 from bits 1:0, kp_rf2 from bits 3:2 and kp_if from bits 5:4. Address 2 holds the power enables: rf_en from bit 0 and if_en from bit 1.
- R6: The dividers are stored from the low data bits. Address 3 is RF1 N (18 bits), address 4 is RF2 N (17 bits) and address 5 is IF N (16 bits). Addresses 6, 7 and 8 are the RF1, RF2 and IF R dividers (13 bits each).
- R7: Writing address 3 or 6 clears rf2_active (RF1 selected). Writing address 4 or 7 sets it. Other writes leave it unchanged.
- R8: A write to any address from 9 to 15 changes no output and raises no strobe.
- R9: Committing address 3 or 6 pulses chg_rf1 for exactly one clock, in the same cycle the value appears. Address 4 or 7 does the same for chg_rf2, and address 5 or 8 for chg_if. Commits to addresses 0 to 2 pulse no strobe.
- R10: After reset, every field is 0, rf2_active is 0 and no strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_dat | input | 1 | Serial data, asynchronous |
| ser_en_n | input | 1 | Serial enable, active low; rising edge commits |
| aux_sel | output | 2 | Auxiliary output selection |
| if_div | output | 2 | IF output divider code |
| ref_div2 | output | 1 | Reference divide-by-two |
| low_pwr | output | 1 | IF output low-power mode |
| auto_pd | output | 1 | Automatic power-up override |
| kp_if | output | 2 | IF phase detector gain code |
| kp_rf2 | output | 2 | RF2 phase detector gain code |
| kp_rf1 | output | 2 | RF1 phase detector gain code |
| if_en | output | 1 | IF section enable |
| rf_en | output | 1 | RF section enable |
| rf1_n | output | 18 | RF1 N divider |
| rf2_n | output | 17 | RF2 N divider |
| if_n | output | 16 | IF N divider |
| rf1_r | output | 13 | RF1 R divider |
| rf2_r | output | 13 | RF2 R divider |
| if_r | output | 13 | IF R divider |
| rf2_active | output | 1 | 1 when RF2 is the active RF loop |
| chg_rf1 | output | 1 | One-cycle RF1 frequency-change strobe |
| chg_rf2 | output | 1 | One-cycle RF2 frequency-change strobe |
| chg_if | output | 1 | One-cycle IF frequency-change strobe |

## Verification
Some rules are checked on every cycle:
- The shift register holds while the synchronized enable is high.
- The stored settings hold between commits.
- A reserved commit leaves every setting and strobe unchanged.
- At most one change strobe is high, and never for two cycles in a row.
- Each strobe agrees with the RF loop selection.

Other behaviour only the bench scenarios can show:
- The bit order, field positions and truncation widths.
- The tolerance of leading junk bits.
- Re-committing after ignored clock edges.
- The exact three-clock commit latency.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;

    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 18;
    localparam int WORD_W  = ADDR_W + DATA_W;
    localparam int RF1N_W  = 18;
    localparam int RF2N_W  = 17;
    localparam int IFN_W   = 16;
    localparam int RDIV_W  = 13;

    typedef enum logic [ADDR_W-1:0] {
        ADR_MAIN  = 4'd0,
        ADR_GAIN  = 4'd1,
        ADR_PWR   = 4'd2,
        ADR_RF1_N = 4'd3,
        ADR_RF2_N = 4'd4,
        ADR_IF_N  = 4'd5,
        ADR_RF1_R = 4'd6,
        ADR_RF2_R = 4'd7,
        ADR_IF_R  = 4'd8
    } reg_addr_e;

    typedef struct packed {
        logic [1:0] aux_sel;
        logic [1:0] if_div;
        logic       ref_div2;
        logic       low_pwr;
        logic       auto_pd;
    } main_cfg_t;

    typedef struct packed {
        logic [1:0] kp_if;
        logic [1:0] kp_rf2;
        logic [1:0] kp_rf1;
    } gain_cfg_t;

    typedef struct packed {
        logic if_en;
        logic rf_en;
    } pwr_cfg_t;

    typedef struct packed {
        logic [RF1N_W-1:0] rf1_n;
        logic [RF2N_W-1:0] rf2_n;
        logic [IFN_W-1:0]  if_n;
        logic [RDIV_W-1:0] rf1_r;
        logic [RDIV_W-1:0] rf2_r;
        logic [RDIV_W-1:0] if_r;
    } div_cfg_t;

    typedef struct packed {
        main_cfg_t main;
        gain_cfg_t gain;
        pwr_cfg_t  pwr;
        div_cfg_t  div;
        logic      rf2_active;
    } cfg_t;

    typedef struct packed {
        logic rf1;
        logic rf2;
        logic ifl;
    } chg_t;

    function automatic main_cfg_t unpack_main(input logic [DATA_W-1:0] d);
        main_cfg_t m;
        m.aux_sel  = d[13:12];
        m.if_div   = d[11:10];
        m.ref_div2 = d[6];
        m.low_pwr  = d[5];
        m.auto_pd  = d[3];
        return m;
    endfunction

    function automatic gain_cfg_t unpack_gain(input logic [DATA_W-1:0] d);
        gain_cfg_t g;
        g.kp_if  = d[5:4];
        g.kp_rf2 = d[3:2];
        g.kp_rf1 = d[1:0];
        return g;
    endfunction

    function automatic pwr_cfg_t unpack_pwr(input logic [DATA_W-1:0] d);
        pwr_cfg_t p;
        p.if_en = d[1];
        p.rf_en = d[0];
        return p;
    endfunction

    function automatic logic addr_reserved(input logic [ADDR_W-1:0] a);
        return a > ADR_IF_R;
    endfunction

endpackage

// File: rtl/synth_cfg_sync.sv
module synth_cfg_sync #(
    parameter int         WIDTH   = 3,
    parameter int         STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);

    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            logic [STAGES-1:0] chain;
            if (STAGES == 1) begin : g_single
                always_ff @(posedge clk) begin
                    if (rst) chain <= RST_VAL[b];
                    else     chain <= d_in[b];
                end
            end else begin : g_multi
                always_ff @(posedge clk) begin
                    if (rst) chain <= {STAGES{RST_VAL[b]}};
                    else     chain <= {chain[STAGES-2:0], d_in[b]};
                end
            end
            assign d_out[b] = chain[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/synth_cfg_shift.sv
module synth_cfg_shift
    import synth_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_s,
    input  logic              sdat_s,
    input  logic              sen_n_s,
    output logic [WORD_W-1:0] word,
    output logic              commit
);

    logic sclk_q;
    logic sen_n_q;
    logic shift_en;
    logic [WORD_W-1:0] sreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q  <= 1'b0;
            sen_n_q <= 1'b1;
        end else begin
            sclk_q  <= sclk_s;
            sen_n_q <= sen_n_s;
        end
    end

    assign shift_en = sclk_s && !sclk_q && !sen_n_s;
    assign commit   = sen_n_s && !sen_n_q;

    always_ff @(posedge clk) begin
        if (rst)           sreg <= '0;
        else if (shift_en) sreg <= {sreg[WORD_W-2:0], sdat_s};
    end

    assign word = sreg;

    AST_SHIFT_GATED: assert property (@(posedge clk) disable iff (rst)
        $past(sen_n_s) |-> $stable(sreg)); // R3

    AST_COMMIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        commit |=> !commit); // R1

endmodule

// File: rtl/synth_cfg_regs.sv
module synth_cfg_regs
    import synth_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  logic [WORD_W-1:0] word,
    output cfg_t              cfg,
    output chg_t              chg
);

    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    cfg_t cfg_nxt;
    chg_t chg_nxt;

    assign addr = word[WORD_W-1:DATA_W];
    assign data = word[DATA_W-1:0];

    always_comb begin
        cfg_nxt = cfg;
        chg_nxt = '0;
        if (commit) begin
            case (addr)
                ADR_MAIN:  cfg_nxt.main = unpack_main(data);
                ADR_GAIN:  cfg_nxt.gain = unpack_gain(data);
                ADR_PWR:   cfg_nxt.pwr  = unpack_pwr(data);
                ADR_RF1_N: begin
                    cfg_nxt.div.rf1_n    = data[RF1N_W-1:0];
                    cfg_nxt.rf2_active   = 1'b0;
                    chg_nxt.rf1          = 1'b1;
                end
                ADR_RF2_N: begin
                    cfg_nxt.div.rf2_n    = data[RF2N_W-1:0];
                    cfg_nxt.rf2_active   = 1'b1;
                    chg_nxt.rf2          = 1'b1;
                end
                ADR_IF_N: begin
                    cfg_nxt.div.if_n     = data[IFN_W-1:0];
                    chg_nxt.ifl          = 1'b1;
                end
                ADR_RF1_R: begin
                    cfg_nxt.div.rf1_r    = data[RDIV_W-1:0];
                    cfg_nxt.rf2_active   = 1'b0;
                    chg_nxt.rf1          = 1'b1;
                end
                ADR_RF2_R: begin
                    cfg_nxt.div.rf2_r    = data[RDIV_W-1:0];
                    cfg_nxt.rf2_active   = 1'b1;
                    chg_nxt.rf2          = 1'b1;
                end
                ADR_IF_R: begin
                    cfg_nxt.div.if_r     = data[RDIV_W-1:0];
                    chg_nxt.ifl          = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
            chg <= '0;
        end else begin
            cfg <= cfg_nxt;
            chg <= chg_nxt;
        end
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(cfg)); // R1

    AST_RESERVED_NO_STORE: assert property (@(posedge clk) disable iff (rst)
        (commit && addr_reserved(addr)) |=> ($stable(cfg) && chg == '0)); // R8

    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(chg)); // R9

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (chg != '0) |=> (chg == '0)); // R9

    AST_RF1_SELECTS: assert property (@(posedge clk) disable iff (rst)
        chg.rf1 |-> !cfg.rf2_active); // R7

    AST_RF2_SELECTS: assert property (@(posedge clk) disable iff (rst)
        chg.rf2 |-> cfg.rf2_active); // R7

    AST_IF_KEEPS_SEL: assert property (@(posedge clk) disable iff (rst)
        chg.ifl |-> $stable(cfg.rf2_active)); // R7

endmodule

// File: rtl/synth_cfg_port.sv
module synth_cfg_port
    import synth_cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ser_clk,
    input  logic                 ser_dat,
    input  logic                 ser_en_n,
    output logic [1:0]           aux_sel,
    output logic [1:0]           if_div,
    output logic                 ref_div2,
    output logic                 low_pwr,
    output logic                 auto_pd,
    output logic [1:0]           kp_if,
    output logic [1:0]           kp_rf2,
    output logic [1:0]           kp_rf1,
    output logic                 if_en,
    output logic                 rf_en,
    output logic [RF1N_W-1:0]    rf1_n,
    output logic [RF2N_W-1:0]    rf2_n,
    output logic [IFN_W-1:0]     if_n,
    output logic [RDIV_W-1:0]    rf1_r,
    output logic [RDIV_W-1:0]    rf2_r,
    output logic [RDIV_W-1:0]    if_r,
    output logic                 rf2_active,
    output logic                 chg_rf1,
    output logic                 chg_rf2,
    output logic                 chg_if
);

    localparam int NUM_WIRES = 3;

    logic [NUM_WIRES-1:0] raw_w;
    logic [NUM_WIRES-1:0] sync_w;
    logic [WORD_W-1:0]    word;
    logic                 commit;
    cfg_t                 cfg;
    chg_t                 chg;

    assign raw_w = {ser_en_n, ser_dat, ser_clk};

    synth_cfg_sync #(
        .WIDTH   (NUM_WIRES),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  (raw_w),
        .d_out (sync_w)
    );

    synth_cfg_shift u_shift (
        .clk     (clk),
        .rst     (rst),
        .sclk_s  (sync_w[0]),
        .sdat_s  (sync_w[1]),
        .sen_n_s (sync_w[2]),
        .word    (word),
        .commit  (commit)
    );

    synth_cfg_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .commit (commit),
        .word   (word),
        .cfg    (cfg),
        .chg    (chg)
    );

    assign aux_sel    = cfg.main.aux_sel;
    assign if_div     = cfg.main.if_div;
    assign ref_div2   = cfg.main.ref_div2;
    assign low_pwr    = cfg.main.low_pwr;
    assign auto_pd    = cfg.main.auto_pd;
    assign kp_if      = cfg.gain.kp_if;
    assign kp_rf2     = cfg.gain.kp_rf2;
    assign kp_rf1     = cfg.gain.kp_rf1;
    assign if_en      = cfg.pwr.if_en;
    assign rf_en      = cfg.pwr.rf_en;
    assign rf1_n      = cfg.div.rf1_n;
    assign rf2_n      = cfg.div.rf2_n;
    assign if_n       = cfg.div.if_n;
    assign rf1_r      = cfg.div.rf1_r;
    assign rf2_r      = cfg.div.rf2_r;
    assign if_r       = cfg.div.if_r;
    assign rf2_active = cfg.rf2_active;
    assign chg_rf1    = chg.rf1;
    assign chg_rf2    = chg.rf2;
    assign chg_if     = chg.ifl;

endmodule

// File: tb/synth_cfg_port_tb_top.sv
`timescale 1ns/1ps
module synth_cfg_port_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_clk = 1'b0;
    logic ser_dat = 1'b0;
    logic ser_en_n = 1'b1;
    logic [1:0] aux_sel, if_div, kp_if, kp_rf2, kp_rf1;
    logic ref_div2, low_pwr, auto_pd, if_en, rf_en;
    logic [17:0] rf1_n;
    logic [16:0] rf2_n;
    logic [15:0] if_n;
    logic [12:0] rf1_r, rf2_r, if_r;
    logic rf2_active, chg_rf1, chg_rf2, chg_if;

    always #10 clk = ~clk;

    synth_cfg_port dut_i (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_en_n(ser_en_n),
        .aux_sel(aux_sel), .if_div(if_div), .ref_div2(ref_div2), .low_pwr(low_pwr),
        .auto_pd(auto_pd), .kp_if(kp_if), .kp_rf2(kp_rf2), .kp_rf1(kp_rf1),
        .if_en(if_en), .rf_en(rf_en), .rf1_n(rf1_n), .rf2_n(rf2_n), .if_n(if_n),
        .rf1_r(rf1_r), .rf2_r(rf2_r), .if_r(if_r), .rf2_active(rf2_active),
        .chg_rf1(chg_rf1), .chg_rf2(chg_rf2), .chg_if(chg_if)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit compare_on = 0;
    bit done = 0;

    // reference model state
    bit q[$];
    int m_aux, m_ifdiv, m_rdiv2, m_lpwr, m_apd;
    int m_kpi, m_kp2, m_kp1, m_ifen, m_rfen;
    int m_rf1n, m_rf2n, m_ifn, m_rf1r, m_rf2r, m_ifr, m_sel;
    int m_p1, m_p2, m_pi;

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_clear();
        m_aux = 0; m_ifdiv = 0; m_rdiv2 = 0; m_lpwr = 0; m_apd = 0;
        m_kpi = 0; m_kp2 = 0; m_kp1 = 0; m_ifen = 0; m_rfen = 0;
        m_rf1n = 0; m_rf2n = 0; m_ifn = 0; m_rf1r = 0; m_rf2r = 0; m_ifr = 0;
        m_sel = 0; m_p1 = 0; m_p2 = 0; m_pi = 0;
    endtask

    task automatic model_commit();
        int w = 0;
        int a, d;
        for (int i = 0; i < 22; i++) begin
            int idx = q.size() - 22 + i;
            w = (w << 1) | ((idx >= 0) ? int'(q[idx]) : 0);
        end
        a = (w >> 18) & 15;
        d = w & 'h3FFFF;
        case (a)
            0: begin
                m_aux = (d >> 12) & 3; m_ifdiv = (d >> 10) & 3;
                m_rdiv2 = (d >> 6) & 1; m_lpwr = (d >> 5) & 1; m_apd = (d >> 3) & 1;
            end
            1: begin m_kp1 = d & 3; m_kp2 = (d >> 2) & 3; m_kpi = (d >> 4) & 3; end
            2: begin m_rfen = d & 1; m_ifen = (d >> 1) & 1; end
            3: begin m_rf1n = d; m_sel = 0; m_p1 = 1; end
            4: begin m_rf2n = d & 'h1FFFF; m_sel = 1; m_p2 = 1; end
            5: begin m_ifn = d & 'hFFFF; m_pi = 1; end
            6: begin m_rf1r = d & 'h1FFF; m_sel = 0; m_p1 = 1; end
            7: begin m_rf2r = d & 'h1FFF; m_sel = 1; m_p2 = 1; end
            8: begin m_ifr = d & 'h1FFF; m_pi = 1; end
            default: ;
        endcase
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (compare_on && !done) begin
            check("R4 main", {aux_sel, if_div, ref_div2, low_pwr, auto_pd},
                  (m_aux << 5) | (m_ifdiv << 3) | (m_rdiv2 << 2) | (m_lpwr << 1) | m_apd);
            check("R5 gain", {kp_if, kp_rf2, kp_rf1}, (m_kpi << 4) | (m_kp2 << 2) | m_kp1);
            check("R5 power", {if_en, rf_en}, (m_ifen << 1) | m_rfen);
            check("R6 rf1_n", rf1_n, m_rf1n);
            check("R6 rf2_n", rf2_n, m_rf2n);
            check("R6 if_n", if_n, m_ifn);
            check("R6 rf1_r", rf1_r, m_rf1r);
            check("R6 rf2_r", rf2_r, m_rf2r);
            check("R6 if_r", if_r, m_ifr);
            check("R7 rf2_active", rf2_active, m_sel);
            check("R9 strobes", {chg_rf1, chg_rf2, chg_if}, (m_p1 << 2) | (m_p2 << 1) | m_pi);
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bit(input bit b, input bit record);
        @(negedge clk);
        ser_dat = b;
        wait_n(4);
        ser_clk = 1'b1;
        if (record) q.push_back(b);
        wait_n(4);
        ser_clk = 1'b0;
    endtask

    task automatic raise_enable();
        wait_n(4);
        ser_en_n = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        model_commit();
        @(posedge clk);
        #1;
        m_p1 = 0; m_p2 = 0; m_pi = 0;
        wait_n(6);
    endtask

    task automatic send_word(input int a, input int d, input int lead);
        int w = ((a & 15) << 18) | (d & 'h3FFFF);
        @(negedge clk);
        ser_en_n = 1'b0;
        wait_n(4);
        for (int i = 0; i < lead; i++) shift_bit(bit'((i % 3) != 1), 1'b1);
        for (int i = 21; i >= 0; i--) shift_bit(bit'((w >> i) & 1), 1'b1);
        raise_enable();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stim
        int snap;
        model_clear();
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        compare_on = 1;
        wait_n(3);
        // R10 reset state
        check("R10 reset fields", {aux_sel, if_div, kp_if, rf1_n, if_en, rf_en}, 0);
        check("R10 reset sel+strobes", {rf2_active, chg_rf1, chg_rf2, chg_if}, 0);

        // main settings with extra bits set that must be dropped
        send_word(0, 'h20000 | (3 << 12) | (2 << 10) | (1 << 6) | (1 << 5) | (1 << 3) | 'h185, 0);
        check("R4 main word", {aux_sel, if_div, ref_div2, low_pwr, auto_pd}, 'b1110111);
        send_word(0, (1 << 12) | (1 << 10) | (1 << 5), 0);
        send_word(1, 'h2D, 0);
        check("R5 gain word", {kp_if, kp_rf2, kp_rf1}, 'b101101);
        send_word(2, 'h2, 0);
        send_word(2, 'h1, 0);

        // dividers and selection
        send_word(3, 'h2AAAA, 0);
        check("R1 rf1_n word", rf1_n, 'h2AAAA);
        send_word(4, 'h3FFFF, 0);
        check("R6 rf2_n truncated", rf2_n, 'h1FFFF);
        check("R7 rf2 selected", rf2_active, 1);
        send_word(5, 'h21234, 0);
        check("R7 IF keeps RF2", rf2_active, 1);
        send_word(6, 'h2ABCD, 0);
        check("R7 rf1 via R", rf2_active, 0);
        send_word(7, 'h1555, 0);
        send_word(8, 'h3FFFF, 0);
        check("R6 if_r truncated", if_r, 'h1FFF);

        // R2 leading junk bits
        send_word(4, 'h0F0F0, 7);
        check("R2 leading bits", rf2_n, 'h0F0F0);
        send_word(3, 'h13579, 30);
        check("R2 long prefix", rf1_n, 'h13579);

        // R8 reserved addresses
        snap = {rf1_n[12:0], rf2_n[12:0], rf2_active};
        for (int a = 9; a < 16; a++) send_word(a, 'h3FFFF, 0);
        check("R8 reserved", {rf1_n[12:0], rf2_n[12:0], rf2_active}, snap);
        check("R8 reserved main", {aux_sel, if_div, ref_div2, low_pwr, auto_pd}, 'b0101010);

        // R3 edges with enable high are ignored; empty frame re-commits
        send_word(5, 'h0BEEF, 0);
        for (int i = 0; i < 6; i++) shift_bit(1'b1, 1'b0);
        @(negedge clk);
        ser_en_n = 1'b0;
        wait_n(6);
        raise_enable();
        check("R3 recommit", if_n, 'hBEEF);
        check("R3 sel unchanged", rf2_active, 0);

        wait_n(5);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule